// File: doc/BRIEF.md
# Active Priority Tracker with Running-Priority Output

This block records which group-priority levels currently hold an active interrupt and turns that record into the running priority. The running priority is the threshold the preemption comparison uses. The record is a vector with one bit per group-priority level. An acknowledge event that carries an 8-bit priority sets the bit for that priority's group. A priority-drop event clears the active level with the highest urgency, which is the lowest set bit. At most one interrupt can be active per group level, so the lowest set bit is enough to find the running priority, and subpriority bits play no part.

The running priority is formed combinationally from the registered vector. A lower numeric value means a higher priority. When nothing is active, the internal value is one step beyond the largest 8-bit code. It is presented as 0xFF, so it never wraps to 0x00, which is the most urgent priority. A plain register port lets software read and overwrite the vector. The same port returns the running priority at a second address.

Top module: `apr_tracker`

## Requirements
- R1: After reset, the vector is all zeros, `run_prio` is 0xFF, `idle` is 1 and `reg_rd_data` is 0.
- R2: An acknowledge with priority p sets vector bit p[7:3] (32 group levels with the default parameters). The effect shows on the outputs in the cycle after the acknowledge is sampled.
- R3: While any bit is set, `run_prio` equals (index of the lowest set bit) × 8. Its three low bits are therefore always 0, and a lower set index always wins over a higher one.
- R4: The subpriority bits p[2:0] have no effect. Acknowledging a level whose bit is already set leaves the vector unchanged.
- R5: A priority drop clears only the lowest set bit, so `run_prio` rises or the block goes idle. A drop while the vector is empty leaves the block idle.
- R6: If an acknowledge and a drop occur in the same cycle, the drop clears the lowest bit of the old vector and the acknowledge bit is then set. An acknowledge of that same lowest level therefore leaves its bit set.
- R7: With no bit set, `run_prio` is 0xFF and `idle` is 1. With bit 0 set, `run_prio` is 0x00 and `idle` is 0.
- R8: A read with `reg_rd_en` returns the vector at address 0 and {24'b0, run_prio} at address 1. The value reflects the state before that clock edge and appears on `reg_rd_data` one cycle later. `reg_rd_data` holds its value while `reg_rd_en` is low.
- R9: A write to address 0 replaces the vector and takes precedence over an acknowledge or drop in the same cycle. A write to address 1 is ignored, and events in that cycle still take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_valid | input | 1 | Acknowledge event this cycle |
| ack_prio | input | PRIO_W (8) | Priority of the acknowledged interrupt |
| drop_valid | input | 1 | Priority-drop event this cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | AW (1) | Register write word address |
| reg_wr_data | input | REG_W (32) | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | AW (1) | Register read word address |
| reg_rd_data | output | REG_W (32) | Registered read data |
| run_prio | output | PRIO_W (8) | Running priority, 0xFF when idle |
| idle | output | 1 | No group level active |

## Verification
An acknowledge, a drop or a vector write is sampled at one clock edge, and its effect on `run_prio` and `idle` is due exactly one edge later, because only the vector register lies on that path. A read strobe is also due one edge later, but it carries the state from before that edge, so a read and an event in the same cycle return the old vector. The driver stamps every expected item with the cycle count at which it falls due. The monitor samples a quarter period after each rising edge and compares only the items whose due cycle has come. A read that is not strobed is checked as the previous value held.

// File: rtl/apr_pkg.sv
package apr_pkg;

    // Source of the next vector value in a cycle.
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_EVENT = 2'd1,
        SRC_WRITE = 2'd2
    } vec_src_e;

    // Kind of register read being served.
    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_VEC  = 2'd1,
        RD_RUN  = 2'd2
    } rd_kind_e;

endpackage

// File: rtl/apr_lowest_enc.sv
module apr_lowest_enc #(
    parameter int LEVELS = 32,
    parameter int IDX_W  = 5
) (
    input  logic [LEVELS-1:0] vec,
    output logic              found,
    output logic [IDX_W-1:0]  idx,
    output logic [LEVELS-1:0] onehot
);

    // Isolate the lowest set bit, then encode its position.
    always_comb begin
        found  = |vec;
        onehot = vec & (~vec + LEVELS'(1));
        idx    = '0;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/apr_rpr_map.sv
module apr_rpr_map #(
    parameter int PRIO_W   = 8,
    parameter int GRP_BITS = 5
) (
    input  logic                found,
    input  logic [GRP_BITS-1:0] idx,
    output logic [PRIO_W:0]     run_int,
    output logic [PRIO_W-1:0]   run_prio
);

    localparam int SHIFT = PRIO_W - GRP_BITS;

    logic [PRIO_W-1:0] level_prio;

    // Place the group index in the top bits; subpriority bits read as zero.
    generate
        if (SHIFT > 0) begin : g_shifted
            assign level_prio = {idx, {SHIFT{1'b0}}};
        end else begin : g_full
            assign level_prio = idx;
        end
    endgenerate

    // The idle code is one beyond the widest priority value.
    always_comb begin
        run_int  = found ? {1'b0, level_prio} : {1'b1, {PRIO_W{1'b0}}};
        run_prio = run_int[PRIO_W] ? {PRIO_W{1'b1}} : run_int[PRIO_W-1:0];
    end

endmodule

// File: rtl/apr_reg_port.sv
module apr_reg_port #(
    parameter int LEVELS = 32,
    parameter int REG_W  = 32,
    parameter int NWORDS = 1,
    parameter int AW     = 1,
    parameter int PRIO_W = 8
) (
    input  logic [LEVELS-1:0] vec,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [AW-1:0]     rd_addr,
    input  logic [PRIO_W-1:0] run_prio,
    output logic              wr_hit,
    output logic [LEVELS-1:0] vec_wr,
    output logic [REG_W-1:0]  rd_word
);

    localparam int PADW = NWORDS * REG_W;

    logic [PADW-1:0]   pad_cur;
    logic [PADW-1:0]   pad_new;
    logic [NWORDS-1:0] hit_w;

    always_comb begin
        pad_cur = '0;
        pad_cur[LEVELS-1:0] = vec;
    end

    // One replace lane per register word.
    generate
        for (genvar w = 0; w < NWORDS; w++) begin : g_word
            assign hit_w[w] = wr_en && (wr_addr == AW'(w));
            assign pad_new[w*REG_W +: REG_W] = hit_w[w] ? wr_data
                                                        : pad_cur[w*REG_W +: REG_W];
        end
    endgenerate

    assign wr_hit = |hit_w;
    assign vec_wr = pad_new[LEVELS-1:0];

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (rd_addr == AW'(w)) begin
                rd_word = pad_cur[w*REG_W +: REG_W];
            end
        end
        if (rd_addr == AW'(NWORDS)) begin
            rd_word = REG_W'(run_prio);
        end
    end

endmodule

// File: rtl/apr_tracker.sv
module apr_tracker #(
    parameter int PRIO_W   = 8,
    parameter int GRP_BITS = 5,
    parameter int REG_W    = 32,
    localparam int LEVELS  = 1 << GRP_BITS,
    localparam int NWORDS  = (LEVELS + REG_W - 1) / REG_W,
    localparam int AW      = $clog2(NWORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_valid,
    input  logic [PRIO_W-1:0] ack_prio,
    input  logic              drop_valid,
    input  logic              reg_wr_en,
    input  logic [AW-1:0]     reg_wr_addr,
    input  logic [REG_W-1:0]  reg_wr_data,
    input  logic              reg_rd_en,
    input  logic [AW-1:0]     reg_rd_addr,
    output logic [REG_W-1:0]  reg_rd_data,
    output logic [PRIO_W-1:0] run_prio,
    output logic              idle
);

    import apr_pkg::*;

    typedef struct packed {
        logic [LEVELS-1:0] vec;
        logic [REG_W-1:0]  rd_data;
    } state_t;

    state_t st_d, st_q;

    logic                found;
    logic [GRP_BITS-1:0] low_idx;
    logic [LEVELS-1:0]   low_onehot;
    logic [PRIO_W:0]     run_int;
    logic                wr_hit;
    logic [LEVELS-1:0]   vec_wr;
    logic [REG_W-1:0]    rd_word;
    logic [LEVELS-1:0]   ack_bit;
    logic [LEVELS-1:0]   drop_mask;
    vec_src_e            src;
    rd_kind_e            rd_kind;

    apr_lowest_enc #(
        .LEVELS (LEVELS),
        .IDX_W  (GRP_BITS)
    ) u_enc (
        .vec    (st_q.vec),
        .found  (found),
        .idx    (low_idx),
        .onehot (low_onehot)
    );

    apr_rpr_map #(
        .PRIO_W   (PRIO_W),
        .GRP_BITS (GRP_BITS)
    ) u_map (
        .found    (found),
        .idx      (low_idx),
        .run_int  (run_int),
        .run_prio (run_prio)
    );

    apr_reg_port #(
        .LEVELS (LEVELS),
        .REG_W  (REG_W),
        .NWORDS (NWORDS),
        .AW     (AW),
        .PRIO_W (PRIO_W)
    ) u_regs (
        .vec      (st_q.vec),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data),
        .rd_addr  (reg_rd_addr),
        .run_prio (run_prio),
        .wr_hit   (wr_hit),
        .vec_wr   (vec_wr),
        .rd_word  (rd_word)
    );

    assign idle = run_int[PRIO_W];

    always_comb begin
        st_d      = st_q;
        ack_bit   = ack_valid  ? (LEVELS'(1) << ack_prio[PRIO_W-1 -: GRP_BITS]) : '0;
        drop_mask = drop_valid ? low_onehot : '0;

        if (wr_hit) begin
            src = SRC_WRITE;
        end else if (ack_valid || drop_valid) begin
            src = SRC_EVENT;
        end else begin
            src = SRC_HOLD;
        end

        case (src)
            SRC_WRITE: st_d.vec = vec_wr;
            SRC_EVENT: st_d.vec = (st_q.vec & ~drop_mask) | ack_bit;
            default:   st_d.vec = st_q.vec;
        endcase

        if (!reg_rd_en) begin
            rd_kind = RD_NONE;
        end else if (reg_rd_addr == AW'(NWORDS)) begin
            rd_kind = RD_RUN;
        end else begin
            rd_kind = RD_VEC;
        end

        if (rd_kind != RD_NONE) begin
            st_d.rd_data = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rd_data = st_q.rd_data;

endmodule

// File: rtl/apr_tracker_chk.sv
module apr_tracker_chk #(
    parameter int PRIO_W   = 8,
    parameter int GRP_BITS = 5,
    parameter int REG_W    = 32,
    parameter int AW       = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_valid,
    input logic [PRIO_W-1:0] ack_prio,
    input logic              drop_valid,
    input logic              reg_wr_en,
    input logic              reg_rd_en,
    input logic [REG_W-1:0]  reg_rd_data,
    input logic [PRIO_W-1:0] run_prio,
    input logic              idle
);

    localparam int SHIFT = PRIO_W - GRP_BITS;
    localparam logic [PRIO_W-1:0] GRP_MASK = {PRIO_W{1'b1}} << SHIFT;

    AST_IDLE_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> run_prio == {PRIO_W{1'b1}}); // R7

    AST_SUBPRIO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> (run_prio & ~GRP_MASK) == '0); // R3

    AST_ACK_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !drop_valid && !reg_wr_en) |=>
            (!idle && run_prio <= ($past(ack_prio) & GRP_MASK))); // R2

    AST_DROP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && drop_valid && !ack_valid && !reg_wr_en) |=> idle); // R5

    AST_DROP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && drop_valid && !ack_valid && !reg_wr_en) |=>
            (idle || run_prio > $past(run_prio))); // R5

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> $stable(reg_rd_data)); // R8

endmodule

bind apr_tracker apr_tracker_chk #(
    .PRIO_W   (PRIO_W),
    .GRP_BITS (GRP_BITS),
    .REG_W    (REG_W),
    .AW       (AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_valid   (ack_valid),
    .ack_prio    (ack_prio),
    .drop_valid  (drop_valid),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_en   (reg_rd_en),
    .reg_rd_data (reg_rd_data),
    .run_prio    (run_prio),
    .idle        (idle)
);

// File: tb/apr_tracker_tb.sv
`timescale 1ns/1ps
module apr_tracker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ack_valid = 1'b0;
    logic [7:0]  ack_prio = '0;
    logic        drop_valid = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [0:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic        reg_rd_en = 1'b0;
    logic [0:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic [7:0]  run_prio;
    logic        idle;

    always #10 clk = ~clk;

    apr_tracker u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_valid   (ack_valid),
        .ack_prio    (ack_prio),
        .drop_valid  (drop_valid),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_en   (reg_rd_en),
        .reg_rd_addr (reg_rd_addr),
        .reg_rd_data (reg_rd_data),
        .run_prio    (run_prio),
        .idle        (idle)
    );

    typedef struct {
        int          due;
        bit          is_rd;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t       sb[$];
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] mv = '0;
    logic [31:0] last_rd = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] exp_run(input logic [31:0] v);
        if (v == 0) return 8'hFF;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) return 8'(i * 8);
        end
        return 8'hFF;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Driver: one operation per cycle, expected results queued with their due cycle.
    task automatic step(input bit ack, input logic [7:0] prio, input bit drop,
                        input bit wr, input logic wa, input logic [31:0] wd,
                        input bit rd, input logic ra, input string req);
        item_t it;
        logic [31:0] old;
        @(negedge clk);
        ack_valid = ack; ack_prio = prio; drop_valid = drop;
        reg_wr_en = wr; reg_wr_addr = wa; reg_wr_data = wd;
        reg_rd_en = rd; reg_rd_addr = ra;
        old = mv;
        if (rd) last_rd = ra ? {24'b0, exp_run(old)} : old;
        if (wr && wa == 1'b0) begin
            mv = wd;
        end else begin
            if (drop) mv = mv & ~(mv & (~mv + 32'd1));
            if (ack)  mv = mv | (32'd1 << prio[7:3]);
        end
        it.due = cyc + 1; it.is_rd = 1'b1; it.exp = last_rd; it.req = req;
        sb.push_back(it);
        it.is_rd = 1'b0; it.exp = {23'b0, (mv == 0), exp_run(mv)};
        sb.push_back(it);
    endtask

    // Monitor: a quarter period after each rising edge.
    initial begin
        forever begin
            item_t it;
            @(posedge clk);
            #5;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                it = sb.pop_front();
                if (it.is_rd) check(it.req, reg_rd_data, it.exp);
                else          check(it.req, {23'b0, idle, run_prio}, it.exp);
            end
        end
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {24'b0, run_prio}, 32'hFF);
        check("R1", {31'b0, idle}, 32'd1);
        check("R1", reg_rd_data, 32'd0);

        step(1, 8'h28, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 8'h2F, 0, 0, 0, 0, 1, 0, "R4");
        step(1, 8'h80, 0, 0, 0, 0, 1, 0, "R3");
        step(1, 8'h13, 0, 0, 0, 0, 0, 0, "R3");
        step(0, 8'h00, 0, 0, 0, 0, 1, 1, "R8");
        step(0, 8'h00, 1, 0, 0, 0, 1, 0, "R5");
        step(1, 8'h00, 1, 0, 0, 0, 1, 0, "R6");
        step(1, 8'h05, 1, 0, 0, 0, 1, 1, "R6");
        step(0, 8'h00, 0, 1, 1, 32'h5, 1, 0, "R9");
        step(1, 8'h08, 1, 1, 0, 32'h400, 1, 0, "R9");
        step(0, 8'h00, 0, 0, 0, 0, 0, 1, "R8");
        step(0, 8'h00, 0, 0, 0, 0, 1, 0, "R8");
        step(1, 8'h00, 0, 1, 1, 32'h0, 1, 1, "R9");
        step(0, 8'h00, 1, 0, 0, 0, 0, 0, "R7");
        step(0, 8'h00, 1, 0, 0, 0, 0, 0, "R5");
        step(0, 8'h00, 1, 0, 0, 0, 1, 1, "R7");
        step(0, 8'h00, 1, 0, 0, 0, 1, 1, "R5");

        for (int i = 31; i >= 0; i--) begin
            step(1, 8'(i * 8 + (i % 8)), 0, 0, 0, 0, 0, 0, "R3");
        end
        step(0, 8'h00, 0, 0, 0, 0, 1, 0, "R2");
        for (int i = 0; i < 32; i++) begin
            step(0, 8'h00, 1, 0, 0, 0, 0, 0, "R5");
        end
        step(0, 8'h00, 0, 0, 0, 0, 1, 1, "R7");

        step(0, 8'h00, 0, 0, 0, 0, 0, 0, "R8");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule